// File: doc/BRIEF.md
# Open-Page Bank Request Scheduler

This block orders memory requests for one DRAM bank and drives the bank's command bus. Requests come in through a valid/ready enqueue port. Each request carries a target row, a request tag and a requester number. Up to `DEPTH` requests wait in a small queue. A row stays in the bank's row buffer after it is used, and it is closed only when a request for a different row is chosen. After reset, a configured row is already open.

Whenever the command engine is idle and the queue holds work, one request is chosen. With `fr_mode` low, the choice is the oldest request. With `fr_mode` high, the choice is the oldest request whose row matches the open row, and the oldest request overall when none matches. The mode is sampled at the moment of selection.

A request that hits the open row needs only a read/write command. A request for another row needs three commands in order: precharge, activate, then read/write. Each command occupies the bank for its own parameterised number of cycles before the next command may go out. When the read/write interval finishes, a one-cycle done pulse returns the request's tag and requester, and the queue slot is freed.

Back-pressure rules for the enqueue port:
- A request transfers on a clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` depends only on queue occupancy and never on `in_valid`.
- A request offered while `in_ready` is low is not taken, and the sender must hold it until `in_ready` rises.
- The done output has no back-pressure.

Top module: `rowbuf_sched`

## Requirements
- R1: After reset, `cmd_code` is 0, `done_valid` is 0, `in_ready` is 1, and row `INIT_ROW` is treated as open.
- R2: A chosen request whose row equals the open row produces exactly one command: read/write (`cmd_code`=3) with `cmd_row` set to that row. `done_valid` is high `T_RW-1` cycles after that command appears.
- R3: A chosen request whose row differs from the open row produces three commands. Precharge (`cmd_code`=1) comes first. Activate (`cmd_code`=2) follows `T_PRE` cycles later, and read/write (3) follows `T_ACT` cycles after the activate. All three carry the request's row on `cmd_row`. Done follows `T_RW-1` cycles after the read/write.
- R4: The row opened by a request stays open after it completes, so a later request to the same row is served as a hit.
- R5: With `fr_mode`=0, requests complete in the order they were accepted.
- R6: With `fr_mode`=1, a waiting request that targets the open row is chosen before any request that does not. Among such hits, the earliest accepted is chosen.
- R7: With `fr_mode`=1 and no waiting request targeting the open row, the earliest accepted request is chosen.
- R8: `in_ready` is low while `DEPTH` requests are outstanding (waiting or in service). A request offered then is not accepted and never completes.
- R9: `done_valid` is a one-cycle pulse. It carries the `in_id` and `in_src` given with that request on `done_id` and `done_src`.
- R10: While the queue is empty, no command is issued and the open row is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fr_mode | input | 1 | 0: arrival order; 1: open-row hits first, then oldest |
| in_valid | input | 1 | Enqueue request valid |
| in_ready | output | 1 | Queue can accept a request |
| in_row | input | ROW_W | Target row of the request |
| in_id | input | ID_W | Request tag returned on completion |
| in_src | input | SRC_W | Requester number returned on completion |
| cmd_code | output | 2 | 0 none, 1 precharge, 2 activate, 3 read/write (one-cycle) |
| cmd_row | output | ROW_W | Row the issued command refers to |
| done_valid | output | 1 | Request completion pulse |
| done_id | output | ID_W | Tag of the completed request |
| done_src | output | SRC_W | Requester of the completed request |

## Verification
The hardest condition to reach from the ports is a real choice by the selector. While the engine is busy, several requests must wait together, with a known open row and a mix of hits and conflicts among them. The stimulus fills the queue on back-to-back cycles while the first request is still in service, then offers one more request to hit the full condition. It sweeps every assignment of four rows drawn from four values, under both modes. An arithmetic model of the selection rule and the per-command intervals predicts the completion order, the command trace and the timing.

// File: rtl/rowbuf_pkg.sv
package rowbuf_pkg;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_PRE  = 2'd1,
    CMD_ACT  = 2'd2,
    CMD_RW   = 2'd3
  } bank_cmd_e;

  typedef enum logic [1:0] {
    EN_IDLE = 2'd0,
    EN_PRE  = 2'd1,
    EN_ACT  = 2'd2,
    EN_RW   = 2'd3
  } eng_state_e;

endpackage

// File: rtl/rowbuf_queue.sv
module rowbuf_queue #(
  parameter int DEPTH = 4,
  parameter int ROW_W = 8,
  parameter int ID_W  = 4,
  parameter int SRC_W = 2,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enq,
  input  logic [ROW_W-1:0] enq_row,
  input  logic [ID_W-1:0]  enq_id,
  input  logic [SRC_W-1:0] enq_src,
  input  logic             free_en,
  input  logic [IDX_W-1:0] free_slot,
  output logic             full,
  output logic             ent_valid [DEPTH],
  output logic [ROW_W-1:0] ent_row   [DEPTH],
  output logic [IDX_W-1:0] ent_rank  [DEPTH],
  output logic [ID_W-1:0]  ent_id    [DEPTH],
  output logic [SRC_W-1:0] ent_src   [DEPTH]
);

  logic [CNT_W-1:0] count;
  logic [IDX_W-1:0] ins_slot;
  logic [IDX_W-1:0] free_rank;
  logic [IDX_W-1:0] new_rank;
  logic [DEPTH-1:0] valid_vec;
  logic [DEPTH-1:0] oldest_vec;

  assign full      = (count == CNT_W'(DEPTH));
  assign free_rank = ent_rank[free_slot];
  assign new_rank  = IDX_W'(count - CNT_W'(free_en));

  // lowest empty slot receives the next request
  always_comb begin
    ins_slot = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!ent_valid[i]) ins_slot = IDX_W'(i);
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_vec
      assign valid_vec[g]  = ent_valid[g];
      assign oldest_vec[g] = ent_valid[g] && (ent_rank[g] == '0);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        ent_valid[i] <= 1'b0;
        ent_row[i]   <= '0;
        ent_rank[i]  <= '0;
        ent_id[i]    <= '0;
        ent_src[i]   <= '0;
      end
    end else begin
      count <= count + CNT_W'(enq) - CNT_W'(free_en);
      for (int i = 0; i < DEPTH; i++) begin
        if (free_en && (free_slot == IDX_W'(i))) begin
          ent_valid[i] <= 1'b0;
        end else if (free_en && ent_valid[i] && (ent_rank[i] > free_rank)) begin
          ent_rank[i] <= ent_rank[i] - IDX_W'(1);
        end
        if (enq && (ins_slot == IDX_W'(i))) begin
          ent_valid[i] <= 1'b1;
          ent_row[i]   <= enq_row;
          ent_id[i]    <= enq_id;
          ent_src[i]   <= enq_src;
          ent_rank[i]  <= new_rank;
        end
      end
    end
  end

  assert_count_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
    count == CNT_W'($countones(valid_vec)));

  assert_oldest_unique_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(oldest_vec));

  assert_oldest_exists_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|valid_vec) |-> (|oldest_vec));

endmodule

// File: rtl/rowbuf_pick.sv
module rowbuf_pick #(
  parameter int DEPTH = 4,
  parameter int ROW_W = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             fr_mode,
  input  logic [ROW_W-1:0] open_row,
  input  logic             ent_valid [DEPTH],
  input  logic [ROW_W-1:0] ent_row   [DEPTH],
  input  logic [IDX_W-1:0] ent_rank  [DEPTH],
  output logic             any_valid,
  output logic             any_hit,
  output logic [IDX_W-1:0] pick_slot,
  output logic [ROW_W-1:0] pick_row,
  output logic             pick_hit
);

  // key: {miss under hit-first mode, arrival rank}; smallest key wins
  always_comb begin
    logic [IDX_W:0] key;
    logic [IDX_W:0] best;
    any_valid = 1'b0;
    any_hit   = 1'b0;
    pick_slot = '0;
    best      = '1;
    for (int i = 0; i < DEPTH; i++) begin
      key = {fr_mode & (ent_row[i] != open_row), ent_rank[i]};
      if (ent_valid[i] && (ent_row[i] == open_row)) any_hit = 1'b1;
      if (ent_valid[i] && (!any_valid || (key < best))) begin
        any_valid = 1'b1;
        best      = key;
        pick_slot = IDX_W'(i);
      end
    end
  end

  assign pick_row = ent_row[pick_slot];
  assign pick_hit = (pick_row == open_row);

endmodule

// File: rtl/rowbuf_engine.sv
module rowbuf_engine
  import rowbuf_pkg::*;
#(
  parameter int ROW_W    = 8,
  parameter int IDX_W    = 2,
  parameter int T_PRE    = 3,
  parameter int T_ACT    = 3,
  parameter int T_RW     = 3,
  parameter int INIT_ROW = 0,
  localparam int T_MAX = (T_PRE > T_ACT) ? ((T_PRE > T_RW) ? T_PRE : T_RW)
                                         : ((T_ACT > T_RW) ? T_ACT : T_RW),
  localparam int CNT_W = $clog2(T_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             any_valid,
  input  logic [IDX_W-1:0] pick_slot,
  input  logic [ROW_W-1:0] pick_row,
  input  logic             pick_hit,
  output logic             idle,
  output logic [ROW_W-1:0] open_row,
  output logic [1:0]       cmd_code,
  output logic [ROW_W-1:0] cmd_row,
  output logic             free_en,
  output logic [IDX_W-1:0] free_slot
);

  eng_state_e       st;
  logic [CNT_W-1:0] cnt;
  logic [ROW_W-1:0] cur_row;
  logic [IDX_W-1:0] cur_slot;
  bank_cmd_e        cmd_q;
  logic             expired;

  assign expired   = (cnt == '0);
  assign idle      = (st == EN_IDLE);
  assign free_en   = (st == EN_RW) && expired;
  assign free_slot = cur_slot;
  assign cmd_code  = cmd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= EN_IDLE;
      cnt      <= '0;
      cur_row  <= '0;
      cur_slot <= '0;
      cmd_q    <= CMD_NONE;
      cmd_row  <= '0;
      open_row <= ROW_W'(INIT_ROW);
    end else begin
      cmd_q <= CMD_NONE;
      unique case (st)
        EN_IDLE: begin
          if (any_valid) begin
            cur_slot <= pick_slot;
            cur_row  <= pick_row;
            cmd_row  <= pick_row;
            if (pick_hit) begin
              st    <= EN_RW;
              cnt   <= CNT_W'(T_RW - 1);
              cmd_q <= CMD_RW;
            end else begin
              st    <= EN_PRE;
              cnt   <= CNT_W'(T_PRE - 1);
              cmd_q <= CMD_PRE;
            end
          end
        end
        EN_PRE: begin
          if (!expired) cnt <= cnt - CNT_W'(1);
          else begin
            st       <= EN_ACT;
            cnt      <= CNT_W'(T_ACT - 1);
            cmd_q    <= CMD_ACT;
            open_row <= cur_row;
          end
        end
        EN_ACT: begin
          if (!expired) cnt <= cnt - CNT_W'(1);
          else begin
            st    <= EN_RW;
            cnt   <= CNT_W'(T_RW - 1);
            cmd_q <= CMD_RW;
          end
        end
        EN_RW: begin
          if (!expired) cnt <= cnt - CNT_W'(1);
          else st <= EN_IDLE;
        end
        default: st <= EN_IDLE;
      endcase
    end
  end

  assert_cmd_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q != CMD_NONE) |-> ($past(st) == EN_IDLE || $past(cnt) == '0));

  assert_act_follows_pre_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_ACT) |-> ($past(st) == EN_PRE));

  assert_rw_on_open_row_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_RW) |-> (cmd_row == open_row));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == EN_IDLE && !$past(any_valid)) |-> (cmd_q == CMD_NONE && $stable(open_row)));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    free_en |=> !free_en);

endmodule

// File: rtl/rowbuf_sched.sv
module rowbuf_sched #(
  parameter int DEPTH    = 4,
  parameter int ROW_W    = 8,
  parameter int ID_W     = 4,
  parameter int SRC_W    = 2,
  parameter int T_PRE    = 3,
  parameter int T_ACT    = 3,
  parameter int T_RW     = 3,
  parameter int INIT_ROW = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fr_mode,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [ROW_W-1:0] in_row,
  input  logic [ID_W-1:0]  in_id,
  input  logic [SRC_W-1:0] in_src,
  output logic [1:0]       cmd_code,
  output logic [ROW_W-1:0] cmd_row,
  output logic             done_valid,
  output logic [ID_W-1:0]  done_id,
  output logic [SRC_W-1:0] done_src
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic             full;
  logic             enq;
  logic             ent_valid [DEPTH];
  logic [ROW_W-1:0] ent_row   [DEPTH];
  logic [IDX_W-1:0] ent_rank  [DEPTH];
  logic [ID_W-1:0]  ent_id    [DEPTH];
  logic [SRC_W-1:0] ent_src   [DEPTH];
  logic             any_valid, any_hit, pick_hit, idle, free_en;
  logic [IDX_W-1:0] pick_slot, free_slot;
  logic [ROW_W-1:0] pick_row, open_row;

  assign in_ready   = !full;
  assign enq        = in_valid && in_ready;
  assign done_valid = free_en;
  assign done_id    = ent_id[free_slot];
  assign done_src   = ent_src[free_slot];

  rowbuf_queue #(.DEPTH(DEPTH), .ROW_W(ROW_W), .ID_W(ID_W), .SRC_W(SRC_W)) u_queue (
    .clk(clk), .rst_n(rst_n), .enq(enq), .enq_row(in_row), .enq_id(in_id),
    .enq_src(in_src), .free_en(free_en), .free_slot(free_slot), .full(full),
    .ent_valid(ent_valid), .ent_row(ent_row), .ent_rank(ent_rank),
    .ent_id(ent_id), .ent_src(ent_src)
  );

  rowbuf_pick #(.DEPTH(DEPTH), .ROW_W(ROW_W)) u_pick (
    .fr_mode(fr_mode), .open_row(open_row), .ent_valid(ent_valid),
    .ent_row(ent_row), .ent_rank(ent_rank), .any_valid(any_valid),
    .any_hit(any_hit), .pick_slot(pick_slot), .pick_row(pick_row),
    .pick_hit(pick_hit)
  );

  rowbuf_engine #(.ROW_W(ROW_W), .IDX_W(IDX_W), .T_PRE(T_PRE), .T_ACT(T_ACT),
                  .T_RW(T_RW), .INIT_ROW(INIT_ROW)) u_engine (
    .clk(clk), .rst_n(rst_n), .any_valid(any_valid), .pick_slot(pick_slot),
    .pick_row(pick_row), .pick_hit(pick_hit), .idle(idle), .open_row(open_row),
    .cmd_code(cmd_code), .cmd_row(cmd_row), .free_en(free_en),
    .free_slot(free_slot)
  );

  assert_fcfs_oldest_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && any_valid && !fr_mode) |-> (ent_rank[pick_slot] == '0));

  assert_hit_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && any_hit && fr_mode) |-> pick_hit);

  assert_miss_oldest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && any_valid && !any_hit) |-> (ent_rank[pick_slot] == '0));

  assert_full_refuses_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !free_en) |=> full);

endmodule

// File: tb/tb_rowbuf_sched.sv
`timescale 1ns/1ps
module tb_rowbuf_sched;

  localparam int DEPTH = 4, ROW_W = 3, ID_W = 3, SRC_W = 2;
  localparam int TP = 2, TA = 4, TR = 3, IR = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fr_mode = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [ROW_W-1:0] in_row = '0;
  logic [ID_W-1:0]  in_id = '0;
  logic [SRC_W-1:0] in_src = '0;
  logic [1:0]       cmd_code;
  logic [ROW_W-1:0] cmd_row;
  logic             done_valid;
  logic [ID_W-1:0]  done_id;
  logic [SRC_W-1:0] done_src;

  always #2 clk = ~clk;

  rowbuf_sched #(.DEPTH(DEPTH), .ROW_W(ROW_W), .ID_W(ID_W), .SRC_W(SRC_W),
                 .T_PRE(TP), .T_ACT(TA), .T_RW(TR), .INIT_ROW(IR)) dut (
    .clk(clk), .rst_n(rst_n), .fr_mode(fr_mode), .in_valid(in_valid),
    .in_ready(in_ready), .in_row(in_row), .in_id(in_id), .in_src(in_src),
    .cmd_code(cmd_code), .cmd_row(cmd_row), .done_valid(done_valid),
    .done_id(done_id), .done_src(done_src)
  );

  int nchk = 0, nerr = 0, cyc = 0;
  int ev_cmd [64], ev_row [64], ev_t [64], n_ev = 0;
  int dn_id [8], dn_src [8], dn_t [8], n_dn = 0;
  int brow [4];
  int m_open = IR;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd_code != 2'd0 && n_ev < 64) begin
        ev_cmd[n_ev] = int'(cmd_code); ev_row[n_ev] = int'(cmd_row); ev_t[n_ev] = cyc;
        n_ev = n_ev + 1;
      end
      if (done_valid && n_dn < 8) begin
        dn_id[n_dn] = int'(done_id); dn_src[n_dn] = int'(done_src); dn_t[n_dn] = cyc;
        n_dn = n_dn + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_batch(input bit mode, input bit first);
    int pend [4];
    int npend, k, open, idx, pos, w;
    bit hit, found;
    string tag;
    fr_mode = mode;
    n_ev = 0; n_dn = 0;
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      in_valid = 1'b1; in_row = ROW_W'(brow[j]); in_id = ID_W'(j); in_src = SRC_W'(3 - j);
      chk(in_ready, "R8 ready while not full", int'(in_ready), 1);
    end
    @(negedge clk);
    in_valid = 1'b1; in_row = '0; in_id = 3'd7; in_src = '0;
    chk(!in_ready, "R8 ready low when full", int'(in_ready), 0);
    @(negedge clk);
    in_valid = 1'b0;
    w = 0;
    while (n_dn < 4 && w < 300) begin @(negedge clk); w++; end
    repeat (8) @(negedge clk);
    // reference: first request is alone, the rest are chosen by rule
    open = m_open; k = 0;
    npend = 3; pend[0] = 1; pend[1] = 2; pend[2] = 3;
    for (int s = 0; s < 4; s++) begin
      if (s == 0) begin idx = 0; tag = "R5 R6 R7 order"; end
      else begin
        pos = 0; found = 1'b0;
        if (mode) begin
          for (int q = 0; q < npend; q++)
            if (!found && brow[pend[q]] == open) begin pos = q; found = 1'b1; end
        end
        idx = pend[pos];
        tag = !mode ? "R5 arrival order" : (found ? "R6 hit first" : "R7 oldest on miss");
        for (int q = pos; q < npend - 1; q++) pend[q] = pend[q + 1];
        npend--;
      end
      hit = (brow[idx] == open);
      chk(dn_id[s] == idx, tag, dn_id[s], idx);
      chk(dn_src[s] == 3 - idx, "R9 requester returned", dn_src[s], 3 - idx);
      if (s > 0) chk(dn_t[s] - dn_t[s-1] > 1, "R9 single-cycle done", dn_t[s] - dn_t[s-1], 2);
      if (k > 60) k = 60;
      if (hit) begin
        chk(ev_cmd[k] == 3, (first && s == 0) ? "R1 initial row open" : "R2 R4 hit is rw only",
            ev_cmd[k], 3);
        chk(ev_row[k] == brow[idx], "R2 hit row", ev_row[k], brow[idx]);
        chk(dn_t[s] - ev_t[k] == TR - 1, "R2 done timing", dn_t[s] - ev_t[k], TR - 1);
        k += 1;
      end else begin
        chk(ev_cmd[k] == 1 && ev_row[k] == brow[idx], "R3 precharge", ev_cmd[k], 1);
        chk(ev_cmd[k+1] == 2 && ev_row[k+1] == brow[idx], "R3 activate", ev_cmd[k+1], 2);
        chk(ev_t[k+1] - ev_t[k] == TP, "R3 precharge interval", ev_t[k+1] - ev_t[k], TP);
        chk(ev_cmd[k+2] == 3 && ev_row[k+2] == brow[idx], "R3 rw after activate", ev_cmd[k+2], 3);
        chk(ev_t[k+2] - ev_t[k+1] == TA, "R3 activate interval", ev_t[k+2] - ev_t[k+1], TA);
        chk(dn_t[s] - ev_t[k+2] == TR - 1, "R3 done timing", dn_t[s] - ev_t[k+2], TR - 1);
        k += 3;
      end
      open = brow[idx];
    end
    chk(n_ev == k, "R10 no command while empty", n_ev, k);
    chk(n_dn == 4, "R8 refused request never completes", n_dn, 4);
    m_open = open;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_code == 2'd0, "R1 no command after reset", int'(cmd_code), 0);
    chk(!done_valid, "R1 no done after reset", int'(done_valid), 0);
    chk(in_ready, "R1 ready after reset", int'(in_ready), 1);
    repeat (4) @(negedge clk);
    chk(n_ev == 0, "R10 idle after reset", n_ev, 0);
    for (int m = 0; m < 2; m++) begin
      for (int p = 0; p < 256; p++) begin
        for (int j = 0; j < 4; j++) brow[j] = (p >> (2 * j)) & 3;
        run_batch(m[0], (m == 0 && p == 0));
      end
    end
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule